// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the word address that a synchronous burst SRAM array sees during a four-beat burst. One external address is captured when either of two active-low address-status strobes is asserted. The processor strobe only counts while chip enable is low. The controller strobe loads whatever the chip enable is doing.

After a load, the two least significant address bits step on every clock where the active-low advance input is low. When advance is high, the current beat is held. A static order-select input picks the stepping rule. With the input low, the low bits count upward modulo four from the start value. With the input high, the low bits are the start value XOR the beat number. The upper address bits stay as loaded. After the fourth beat the sequence returns to the start address. A flag marks the fourth beat.

Top module: `burst_addr_seq`

## Requirements
- R1: A low controller strobe (`ads_ctrl_n`) on a rising edge loads `ext_addr` into the address, whatever `chip_en_n` is. From the next cycle, `mem_addr` equals the loaded value.
- R2: A low processor strobe (`ads_proc_n`) with `chip_en_n` low on a rising edge loads `ext_addr` in the same way.
- R3: A low processor strobe with `chip_en_n` high does not load. The burst steps or holds as `adv_n` dictates.
- R4: With no load and `adv_n` low, the beat number advances by one on each rising edge.
- R5: With no load and `adv_n` high, `mem_addr` and `last_beat` keep their values.
- R6: With `order_ilv` = 0, the low two bits on beat k (k = 0..3) are (start + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R7: With `order_ilv` = 1, the low two bits on beat k are start XOR k. For example, a start of 01 gives 01, 00, 11, 10.
- R8: Advancing past beat 3 returns to beat 0, which is the loaded start address.
- R9: Bits `AW-1:2` of `mem_addr` do not change except on a load.
- R10: When a load and an advance occur in the same cycle, the load wins and the beat number becomes 0.
- R11: A synchronous reset (`rst` high) sets `mem_addr` to 0 and beat 0, with `last_beat` low.
- R12: `last_beat` is high exactly when the beat number is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | AW | External start address |
| ads_proc_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| ads_ctrl_n | input | 1 | Controller address strobe, active low, ungated |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Order select: 0 linear, 1 interleaved; static |
| mem_addr | output | AW | Array word address |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
The bench builds the block with the default 17-bit address. With this width, the upper-bit hold can be checked against start addresses whose upper bits are all ones, all zeros or random. The bench runs once with each setting of the order input, changing it only under reset. In each run it uses all four start values, uses both strobes under both chip-enable levels, suspends bursts and wraps them, and loads while advancing.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          ads_proc_n,
  input  logic          ads_ctrl_n,
  input  logic          chip_en_n,
  input  logic          adv_n,
  input  logic          order_ilv,
  output logic [AW-1:0] mem_addr,
  output logic          last_beat
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic [1:0]    low_bits;
  logic          load;

  assign load = !ads_ctrl_n || (!ads_proc_n && !chip_en_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= 2'd0;
    end else if (load) begin
      base_q <= ext_addr;
      beat_q <= 2'd0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low_bits  = order_ilv ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign mem_addr  = {base_q[AW-1:2], low_bits};
  assign last_beat = (beat_q == 2'd3);
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ext_addr,
  input logic          ads_proc_n,
  input logic          ads_ctrl_n,
  input logic          chip_en_n,
  input logic          adv_n,
  input logic [AW-1:0] mem_addr,
  input logic          last_beat
);
  logic ld;
  assign ld = !ads_ctrl_n || (!ads_proc_n && !chip_en_n);

  // R1
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ads_ctrl_n |=> mem_addr == $past(ext_addr));
  // R2
  proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!ads_proc_n && !chip_en_n) |=> mem_addr == $past(ext_addr));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=> ($stable(mem_addr) && $stable(last_beat)));
  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(mem_addr[AW-1:2]));
  // R10
  load_first_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> !last_beat);
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n && last_beat) |=> !last_beat);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ext_addr(ext_addr), .ads_proc_n(ads_proc_n),
  .ads_ctrl_n(ads_ctrl_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
  .mem_addr(mem_addr), .last_beat(last_beat)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 17;
  logic clk = 0;
  logic rst = 1;
  logic [AW-1:0] ext_addr = '0;
  logic ads_proc_n = 1, ads_ctrl_n = 1, chip_en_n = 1, adv_n = 1, order_ilv = 0;
  logic [AW-1:0] mem_addr;
  logic last_beat;

  int checks = 0, errors = 0;
  string tag = "R11";
  int m_base = 0, m_beat = 0;

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .order_ilv(order_ilv), .mem_addr(mem_addr), .last_beat(last_beat)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_base = 0; m_beat = 0;
    end else if (!ads_ctrl_n || (!ads_proc_n && !chip_en_n)) begin
      m_base = int'(ext_addr); m_beat = 0;
    end else if (!adv_n) begin
      m_beat = (m_beat + 1) % 4;
    end
  end

  function automatic int exp_addr();
    int lo;
    lo = order_ilv ? ((m_base % 4) ^ m_beat) : (((m_base % 4) + m_beat) % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic compare();
    int e;
    e = exp_addr();
    checks++;
    if (int'(mem_addr) != e) begin
      errors++;
      $display("FAIL %s: mem_addr=%h expected %h", tag, mem_addr, e);
    end
    checks++;
    if (int'(mem_addr[AW-1:2]) != m_base / 4) begin
      errors++;
      $display("FAIL R9: upper=%h expected %h", mem_addr[AW-1:2], m_base / 4);
    end
    checks++;
    if (last_beat != (m_beat == 3)) begin
      errors++;
      $display("FAIL R12: last_beat=%b expected %b", last_beat, m_beat == 3);
    end
  endtask

  task automatic step(input logic c_n, input logic p_n, input logic ce_n,
                      input logic a_n, input logic [AW-1:0] ad);
    @(negedge clk);
    compare();
    ads_ctrl_n = c_n; ads_proc_n = p_n; chip_en_n = ce_n; adv_n = a_n; ext_addr = ad;
  endtask

  task automatic run_mode(input logic mode);
    rst = 1; order_ilv = mode;
    tag = "R11";
    repeat (3) step(1, 1, 1, 1, '0);
    rst = 0;
    for (int s = 0; s < 4; s++) begin
      tag = "R1";
      step(0, 1, 1, 1, {15'h7fff, 2'(s)});
      tag = mode ? "R7" : "R6";
      step(1, 1, 1, 0, '0);
      tag = "R4";
      step(1, 1, 1, 0, '0);
      step(1, 1, 1, 0, '0);
      tag = "R8";
      step(1, 1, 1, 0, '0);
      step(1, 1, 1, 1, '0);
    end
    tag = "R2";
    step(1, 0, 0, 1, 17'h0a5a6);
    tag = "R5";
    step(1, 1, 1, 0, '0);
    step(1, 1, 1, 1, '0);
    step(1, 1, 1, 1, '0);
    tag = "R3";
    step(1, 0, 1, 0, 17'h15555);
    step(1, 0, 1, 1, 17'h12223);
    step(1, 0, 1, 0, 17'h1ffff);
    tag = "R10";
    step(1, 1, 1, 0, '0);
    step(0, 1, 1, 0, 17'h00003);
    step(1, 0, 0, 0, 17'h1c001);
    step(1, 1, 1, 0, '0);
    tag = mode ? "R7" : "R6";
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 16;
      step(r > 1, (r % 3) != 0, $urandom % 2, $urandom % 3 == 0, AW'($urandom));
    end
    tag = "R11";
    @(negedge clk); compare(); rst = 1;
    step(1, 1, 1, 0, '0);
    step(1, 1, 1, 0, '0);
    rst = 0;
  endtask

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    step(1, 1, 1, 1, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule